// File: doc/BRIEF.md
# Iterative Logical Right Shifter

This block is a multi-cycle execution unit for a small processor datapath. It performs a logical right shift of a byte, word or double-word operand by an unsigned 5-bit count. The vacated high positions within the selected width are filled with zeros. The last bit that leaves the low end is returned as the carry flag. The unit also returns negative and zero flags.

The datapath moves the operand at most two bit positions per clock. A separate latency counter makes the done pulse appear after a fixed number of clocks. That number depends only on the operand size and the count, not on the data. A double-word operand arrives and leaves as two 16-bit halves, low half and high half, as it would from an aligned even/odd register pair. The previous carry and negative flags are supplied alongside the operand. A zero count can then leave them as they were.

A start strobe launches one operation. While an operation is in flight, `busy` is high and any further strobe is ignored. Results and flags are registered and hold their values until the next operation completes.

Top module: `lsr_iter_unit`

## Requirements
- R1: The result equals the operand, limited to the selected width, shifted right by `count`. Every bit above the selected width reads 0. For byte and word, `result_hi` is 0. For byte, `result_lo[15:8]` is also 0.
- R2: For a nonzero count, `c` is the last bit shifted out. That is operand bit `count-1` when `count` does not exceed the width, and 0 when `count` exceeds the width.
- R3: With `count` = 0 no shift occurs. The result is the width-limited operand, and `c` and `n` equal the `c_prev` and `n_prev` values sampled with the start strobe.
- R4: After any operation with a nonzero count, `n` is 0.
- R5: `z` is 1 exactly when the result within the selected width is all zeros, including the zero-count case.
- R6: `size` encodes 2'b00 = 8 bits, 2'b01 = 16 bits and 2'b10 = 32 bits. 2'b11 is handled as 32 bits.
- R7: Count the clock edge that accepts `start` as clock 1. `done` is first high after clock L and stays high for exactly one cycle. L = 4 + ceil(count/2) for 8 and 16 bits, and L = 6 + ceil(count/2) for 32 bits.
- R8: `busy` is high from the accepting edge until the edge that raises `done`, and is low while `done` is high. A `start` seen while `busy` is high changes neither the result nor the latency.
- R9: `result_lo`, `result_hi`, `c`, `n` and `z` change only at the edge that raises `done`, and otherwise hold their values.
- R10: For byte and word sizes, `operand_hi` has no effect on any output.
- R11: A synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch strobe, accepted when not busy |
| size | input | 2 | Operand size: 00 byte, 01 word, 10/11 double word |
| count | input | 5 | Shift distance, 0 to 31 |
| operand_lo | input | 16 | Operand low half (even register) |
| operand_hi | input | 16 | Operand high half (odd register), double word only |
| c_prev | input | 1 | Current carry flag, kept on zero count |
| n_prev | input | 1 | Current negative flag, kept on zero count |
| result_lo | output | 16 | Result low half |
| result_hi | output | 16 | Result high half |
| c | output | 1 | Carry flag |
| n | output | 1 | Negative flag |
| z | output | 1 | Zero flag |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default parameters: 16-bit halves, a 5-bit count, two bits per step, and base latencies of 4 and 6. With a 5-bit count, every count from 0 to 31 can be swept on each size. That sweep reaches counts above the byte and word widths, where the result and carry must be zero, and both parities of the count, where the rounded-up step term is checked. It also reaches the count equal to the width, where the carry is the old top bit.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_RSVD  = 2'b11
  } size_e;

  // Sizes 10 and 11 both select the full double-word width.
  function automatic logic is_wide(input size_e s);
    return (s == SZ_DWORD) || (s == SZ_RSVD);
  endfunction

endpackage

// File: rtl/lsr_latency.sv
module lsr_latency
  import lsr_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int STEP        = 2,
  parameter int BASE_NARROW = 4,
  parameter int BASE_WIDE   = 6,
  parameter int LAT_W       = 5
) (
  input  logic [1:0]       size,
  input  logic [CNT_W-1:0] count,
  output logic [LAT_W-1:0] wait_init
);

  int steps;
  int base;

  // Total latency L = base + ceil(count/STEP); the counter is loaded with L-2
  // so that done rises on the L-th edge counting the accepting edge as the first.
  always_comb begin
    steps     = (int'(count) + STEP - 1) / STEP;
    base      = is_wide(size_e'(size)) ? BASE_WIDE : BASE_NARROW;
    wait_init = LAT_W'(base + steps - 2);
  end

endmodule

// File: rtl/lsr_ctrl.sv
module lsr_ctrl #(
  parameter int LAT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LAT_W-1:0] wait_init,
  output logic             accept,
  output logic             busy_q,
  output logic             finish
);

  logic [LAT_W-1:0] cnt_q;

  assign accept = start && !busy_q;
  assign finish = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= wait_init;
    end else if (finish) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R7: while waiting, the counter moves down by exactly one each clock
  a_r7_countdown: assert property (@(posedge clk) disable iff (rst)
    busy_q && (cnt_q != '0) |=> busy_q && (cnt_q == $past(cnt_q) - 1'b1));

  // R8: a start during the run does not reload or extend the counter
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
    busy_q && start && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R8: the run ends right after the counter expires
  a_r8_busy_drops: assert property (@(posedge clk) disable iff (rst)
    finish |=> !busy_q);

endmodule

// File: rtl/lsr_shift_path.sv
module lsr_shift_path
  import lsr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [1:0]        size,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] opnd,
  input  logic              c_init,
  output logic [DATA_W-1:0] data_q,
  output logic              carry_q,
  output logic [CNT_W-1:0]  left_q
);

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam logic [CNT_W-1:0] STEP_C = CNT_W'(STEP);

  logic [DATA_W-1:0] mask;
  logic [CNT_W-1:0]  amt;
  logic [CNT_W-1:0]  amt_m1;

  always_comb begin
    case (size_e'(size))
      SZ_BYTE: mask = DATA_W'({BYTE_W{1'b1}});
      SZ_WORD: mask = DATA_W'({WORD_W{1'b1}});
      default: mask = '1;
    endcase
  end

  // A step moves STEP bits, or fewer on the final step of an odd remainder.
  assign amt    = (left_q >= STEP_C) ? STEP_C : left_q;
  assign amt_m1 = amt - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      carry_q <= 1'b0;
      left_q  <= '0;
    end else if (load) begin
      data_q  <= opnd & mask;
      carry_q <= c_init;
      left_q  <= count;
    end else if (left_q != '0) begin
      carry_q <= data_q[amt_m1];
      data_q  <= data_q >> amt;
      left_q  <= left_q - amt;
    end
  end

  // R7: every step makes progress toward the end of the shift
  a_r7_progress: assert property (@(posedge clk) disable iff (rst)
    !load && (left_q != '0) |=> left_q < $past(left_q));

  // R1: any step leaves the top position zero-filled
  a_r1_zero_fill: assert property (@(posedge clk) disable iff (rst)
    !load && (left_q != '0) |=> !data_q[DATA_W-1]);

endmodule

// File: rtl/lsr_iter_unit.sv
module lsr_iter_unit
  import lsr_pkg::*;
#(
  parameter int HALF_W      = 16,
  parameter int CNT_W       = 5,
  parameter int STEP        = 2,
  parameter int BASE_NARROW = 4,
  parameter int BASE_WIDE   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        size,
  input  logic [CNT_W-1:0]  count,
  input  logic [HALF_W-1:0] operand_lo,
  input  logic [HALF_W-1:0] operand_hi,
  input  logic              c_prev,
  input  logic              n_prev,
  output logic [HALF_W-1:0] result_lo,
  output logic [HALF_W-1:0] result_hi,
  output logic              c,
  output logic              n,
  output logic              z,
  output logic              busy,
  output logic              done
);

  localparam int DATA_W    = 2 * HALF_W;
  localparam int MAX_STEPS = ((1 << CNT_W) - 1 + STEP - 1) / STEP;
  localparam int MAX_LAT   = BASE_WIDE + MAX_STEPS;
  localparam int LAT_W     = $clog2(MAX_LAT + 1);

  logic              accept;
  logic              busy_q;
  logic              finish;
  logic [LAT_W-1:0]  wait_init;
  logic [DATA_W-1:0] data_q;
  logic              carry_q;
  logic [CNT_W-1:0]  left_q;
  logic              zero_cnt_q;
  logic              n_cap_q;

  lsr_latency #(
    .CNT_W(CNT_W), .STEP(STEP), .BASE_NARROW(BASE_NARROW),
    .BASE_WIDE(BASE_WIDE), .LAT_W(LAT_W)
  ) u_lat (
    .size(size), .count(count), .wait_init(wait_init)
  );

  lsr_ctrl #(.LAT_W(LAT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .wait_init(wait_init),
    .accept(accept), .busy_q(busy_q), .finish(finish)
  );

  lsr_shift_path #(.DATA_W(DATA_W), .CNT_W(CNT_W), .STEP(STEP)) u_path (
    .clk(clk), .rst(rst), .load(accept), .size(size), .count(count),
    .opnd({operand_hi, operand_lo}), .c_init(c_prev),
    .data_q(data_q), .carry_q(carry_q), .left_q(left_q)
  );

  assign busy = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_cnt_q <= 1'b0;
      n_cap_q    <= 1'b0;
    end else if (accept) begin
      zero_cnt_q <= (count == '0);
      n_cap_q    <= n_prev;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_lo <= '0;
      result_hi <= '0;
      c         <= 1'b0;
      n         <= 1'b0;
      z         <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        result_lo <= data_q[HALF_W-1:0];
        result_hi <= data_q[DATA_W-1:HALF_W];
        c         <= carry_q;
        n         <= zero_cnt_q ? n_cap_q : 1'b0;
        z         <= (data_q == '0);
      end
    end
  end

  // R7: the latency window always covers the whole shift
  a_r7_shift_complete: assert property (@(posedge clk) disable iff (rst)
    finish |-> (left_q == '0));

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: busy and done never overlap
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9: outputs hold outside the completing edge
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !finish |=> $stable({result_hi, result_lo, c, n, z}));

  // R4: any nonzero shift clears the negative flag
  a_r4_n_cleared: assert property (@(posedge clk) disable iff (rst)
    finish && !zero_cnt_q |=> !n);

endmodule

// File: tb/lsr_iter_unit_test.sv
module lsr_iter_unit_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  size = 2'b00;
  logic [4:0]  count = '0;
  logic [15:0] operand_lo = '0;
  logic [15:0] operand_hi = '0;
  logic        c_prev = 1'b0;
  logic        n_prev = 1'b0;
  logic [15:0] result_lo;
  logic [15:0] result_hi;
  logic        c;
  logic        n;
  logic        z;
  logic        busy;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  lsr_iter_unit uut (
    .clk(clk), .rst(rst), .start(start), .size(size), .count(count),
    .operand_lo(operand_lo), .operand_hi(operand_hi),
    .c_prev(c_prev), .n_prev(n_prev),
    .result_lo(result_lo), .result_hi(result_hi),
    .c(c), .n(n), .z(z), .busy(busy), .done(done)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int width_of(input logic [1:0] s);
    return (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
  endfunction

  function automatic int lat_of(input logic [1:0] s, input int k);
    return ((s == 2'b00 || s == 2'b01) ? 4 : 6) + (k + 1) / 2;
  endfunction

  // Independent reference per R1..R6
  task automatic expect_vals(input logic [1:0] s, input int k,
                             input logic [15:0] lo, input logic [15:0] hi,
                             input logic cp, input logic np,
                             output logic [31:0] r, output logic ec,
                             output logic en, output logic ez);
    int w;
    logic [31:0] full;
    w = width_of(s);
    full = {hi, lo};
    if (w < 32) full = full & ((32'd1 << w) - 1);
    if (k == 0) begin
      r = full; ec = cp; en = np;
    end else begin
      r = full >> k;
      ec = (k > w) ? 1'b0 : full[k-1];
      en = 1'b0;
    end
    ez = (r == 0);
  endtask

  // Launch, optionally poke start mid-run, wait for done and check it all.
  task automatic run_op(input string req, input logic [1:0] s, input int k,
                        input logic [15:0] lo, input logic [15:0] hi,
                        input logic cp, input logic np, input bit poke);
    logic [31:0] er;
    logic ec, en, ez;
    int cyc;
    expect_vals(s, k, lo, hi, cp, np, er, ec, en, ez);
    @(negedge clk);
    size = s; count = 5'(k); operand_lo = lo; operand_hi = hi;
    c_prev = cp; n_prev = np; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    if (k == 0 || poke) check("R8", "busy after accept", 64'(busy), 64'd1);
    while (!done && cyc < 100) begin
      if (poke && cyc == 2) begin
        start = 1'b1; count = 5'd1; operand_lo = ~lo; operand_hi = ~hi;
        size = 2'b10; c_prev = ~cp; n_prev = ~np;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check("R7", $sformatf("latency s=%0d k=%0d", s, k), 64'(cyc), 64'(lat_of(s, k)));
    check("R8", "busy low with done", 64'(busy), 64'd0);
    check("R1", $sformatf("result s=%0d k=%0d", s, k), 64'({result_hi, result_lo}), 64'(er));
    check("R2", $sformatf("carry s=%0d k=%0d", s, k), 64'(c), 64'(ec));
    check(k == 0 ? "R3" : "R4", "negative flag", 64'(n), 64'(en));
    check("R5", "zero flag", 64'(z), 64'(ez));
    @(negedge clk);
    check("R7", "done one cycle", 64'(done), 64'd0);
  endtask

  task automatic t_reset();
    check("R11", "result after reset", 64'({result_hi, result_lo}), 64'd0);
    check("R11", "flags after reset", 64'({c, n, z, busy, done}), 64'd0);
  endtask

  task automatic t_sweep();
    for (int s = 0; s < 3; s++)
      for (int k = 0; k < 32; k++)
        run_op("R7", 2'(s), k, 16'hB5A7 ^ 16'(k * 37), 16'hC3E1 + 16'(k), k[0], ~k[1], 1'b0);
  endtask

  task automatic t_zero_count();
    run_op("R3", 2'b10, 0, 16'h0000, 16'h8000, 1'b1, 1'b1, 1'b0);
    run_op("R3", 2'b00, 0, 16'hFF00, 16'hFFFF, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_over_width();
    run_op("R2", 2'b00, 9, 16'h00FF, 16'h0000, 1'b1, 1'b0, 1'b0);
    run_op("R2", 2'b00, 8, 16'h0080, 16'h0000, 1'b0, 1'b0, 1'b0);
    run_op("R2", 2'b01, 16, 16'h8000, 16'h0000, 1'b0, 1'b0, 1'b0);
    run_op("R2", 2'b10, 31, 16'h0000, 16'hC000, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_rsvd_size();
    run_op("R6", 2'b11, 5, 16'h1234, 16'hF00D, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_hi_ignored();
    logic [31:0] a;
    run_op("R10", 2'b01, 3, 16'h00F8, 16'h0000, 1'b0, 1'b0, 1'b0);
    a = {result_hi, result_lo};
    run_op("R10", 2'b01, 3, 16'h00F8, 16'hFFFF, 1'b0, 1'b0, 1'b0);
    check("R10", "operand_hi effect", 64'({result_hi, result_lo}), 64'(a));
  endtask

  task automatic t_busy_poke();
    run_op("R8", 2'b01, 7, 16'hA5F0, 16'h0000, 1'b0, 1'b1, 1'b1);
    run_op("R8", 2'b10, 20, 16'h0F0F, 16'h8421, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_hold();
    logic [35:0] snap;
    snap = {result_hi, result_lo, c, n, z, busy};
    size = 2'b10; count = 5'd3; operand_lo = 16'h5555; operand_hi = 16'hAAAA;
    c_prev = ~c_prev; n_prev = ~n_prev;
    for (int i = 0; i < 5; i++) @(negedge clk);
    check("R9", "outputs held", 64'({result_hi, result_lo, c, n, z, busy}), 64'(snap));
    check("R9", "no done while idle", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero_count();
    t_over_width();
    t_rsvd_size();
    t_hi_ignored();
    t_busy_poke();
    t_hold();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule